// File: doc/BRIEF.md
# Transaction Checkpoint and Backoff Controller

This per-core controller runs the life cycle of a hardware transaction around a simple core. Software opens and closes a transaction by writing a command word to one fixed control address. When a transaction opens, the controller stalls the pipeline and copies the whole register file, one word per cycle, into a private scratchpad. It then lets the core run speculatively until either a commit command arrives or the conflict input fires.

On a conflict the controller stops the transaction and copies the scratchpad back into the register file, again one word per cycle. It then holds the core stalled in a low-power state for a backoff period, and after that pulses a restart output so the core re-runs the transaction. The first backoff of a transaction is a pseudo-random count below 100 cycles. Each further conflict before a commit doubles the previous wait, up to a ceiling. A successful commit forgets the history, so the next conflict draws a fresh short wait.

Top module: `txn_ckpt_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, stall, low_power, restart and txn_active are 0, and neither sp_we nor rf_we is asserted.
- R2: A write of value 1 to CTRL_ADDR while idle starts a checkpoint on the next cycle. For k = 0 to NREGS-1 in ascending order, one per cycle, sp_we is 1, sp_addr is k, rf_raddr is k and sp_wdata equals rf_rdata. stall is 1 throughout. On the cycle after the last word, txn_active is 1 and stall is 0.
- R3: A write to any other address, a write to CTRL_ADDR of any value other than 0 or 1, a start write while a transaction is not idle, and a stop write while idle all leave every output unchanged.
- R4: A write of value 0 to CTRL_ADDR while txn_active is 1 commits. txn_active and stall are 0 on the next cycle, and no register-file write follows.
- R5: The conflict input asserted while txn_active is 1 begins a restore on the next cycle. For k = 0 to NREGS-1 in ascending order, one per cycle, rf_we is 1, rf_waddr is k and rf_wdata equals sp_rdata read at sp_addr k. stall is 1 throughout. If the conflict input and a stop write arrive on the same cycle, the conflict wins.
- R6: A conflict during the checkpoint does not cut it short. All NREGS words are saved first, and the restore starts on the very next cycle without txn_active ever rising.
- R7: The restore, the low-power wait and the restart happen in that order. low_power rises on the cycle after the last restore write and stays 1 for exactly D cycles with stall held at 1. restart is then 1 for one cycle, and the controller is idle with stall at 0 on the cycle after that.
- R8: The first backoff D after reset or after a commit satisfies 1 <= D <= 99. It is drawn from a free-running 16-bit pseudo-random generator.
- R9: Each further conflict before a commit makes D equal to the smaller of twice the previous D and 2^BACKOFF_W - 1.
- R10: A commit clears the doubling history, so the next conflict again yields 1 <= D <= 99.
- R11: The conflict input is ignored while idle, while restoring and during the backoff wait. It neither starts a restore nor changes the length of the wait, nor does it change the D of the following conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Memory-mapped write strobe |
| ctl_addr | input | AW | Memory-mapped write address |
| ctl_wdata | input | XLEN | Write data: 1 starts, 0 commits |
| rf_raddr | output | $clog2(NREGS) | Register-file read index during checkpoint |
| rf_rdata | input | XLEN | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write strobe during restore |
| rf_waddr | output | $clog2(NREGS) | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| sp_we | output | 1 | Scratchpad write strobe during checkpoint |
| sp_addr | output | $clog2(NREGS) | Scratchpad word index |
| sp_wdata | output | XLEN | Scratchpad write data |
| sp_rdata | input | XLEN | Scratchpad read data (same cycle) |
| abort_in | input | 1 | Conflict detected for this core |
| stall | output | 1 | Hold the pipeline |
| low_power | output | 1 | Core in low-power backoff |
| restart | output | 1 | One-cycle pulse: re-run the transaction |
| txn_active | output | 1 | Transaction executing speculatively |

## Verification
On every cycle the assertions check the shape of the copy phases. Scratchpad and register-file writes never overlap. Indices start at zero and climb by one. The pipeline is held during any copy or backoff, low power only begins straight after a restore write, and restart is a single pulse leaving the core free to run. The data integrity of the round trip only shows in the bench's scenarios: the saved words equal the live registers, and a corrupted file comes back intact. The same holds for the exact backoff lengths: first draw below 100, exact doubling, saturation at the ceiling and a fresh draw after commit. The scenarios also show that conflicts arriving during a checkpoint, during a wait or while idle are handled as required.

// File: rtl/txn_pkg.sv
// Shared types for the transaction checkpoint controller.
// Assumes: one controller per core, states encoded in three bits.
package txn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAVE    = 3'd1,
        ST_RUN     = 3'd2,
        ST_RESTORE = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_WAKE    = 3'd5
    } txn_state_e;
endpackage

// File: rtl/txn_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
// Assumes: SEED is non-zero; advances every cycle out of reset.
module txn_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    // Shift one step per cycle, folding taps when the output bit is 1.
    always_ff @(posedge clk) begin
        if (!rst_n)        value <= SEED;
        else if (value[0]) value <= (value >> 1) ^ TAPS;
        else               value <= value >> 1;
    end
endmodule

// File: rtl/txn_copy_seq.sv
// Word index sequencer shared by the checkpoint save and restore phases.
// Assumes: callers only advance it inside a copy phase; it wraps to 0
// after the last word, so every phase starts from index 0.
module txn_copy_seq #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    assign last = (idx == LAST_IDX);

    // Step the index one word per advancing cycle, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= last ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/txn_backoff.sv
// Backoff length keeper and countdown for one core.
// Assumes: arm fires once at the end of each restore; commit clears
// the doubling history; count_en decrements while waiting.
module txn_backoff #(
    parameter int BW   = 16,
    parameter int LW   = 16,
    parameter int SPAN = 99
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rand_in,
    input  logic          arm,
    input  logic          commit,
    input  logic          count_en,
    output logic          expired
);
    localparam logic [BW-1:0] SAT_MAX = {BW{1'b1}};

    logic [BW-1:0] delay_q;
    logic [BW-1:0] cnt_q;
    logic          retry_q;
    logic [BW-1:0] first_delay;
    logic [BW:0]   doubled;
    logic [BW-1:0] next_delay;

    // Fresh draw in 1..SPAN, or the previous delay doubled with saturation.
    always_comb begin
        first_delay = BW'(rand_in % LW'(SPAN)) + 1'b1;
        doubled     = {delay_q, 1'b0};
        if (!retry_q)       next_delay = first_delay;
        else if (doubled[BW]) next_delay = SAT_MAX;
        else                next_delay = doubled[BW-1:0];
    end

    assign expired = (cnt_q == BW'(1));

    // Hold delay history and count down the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q <= '0;
            cnt_q   <= '0;
            retry_q <= 1'b0;
        end else begin
            if (arm) begin
                delay_q <= next_delay;
                cnt_q   <= next_delay;
                retry_q <= 1'b1;
            end else if (count_en) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (commit) retry_q <= 1'b0;
        end
    end
endmodule

// File: rtl/txn_ckpt_ctrl.sv
// Per-core transaction controller: register checkpoint on start,
// restore plus low-power exponential backoff on conflict, commit on stop.
// Assumes: register file and scratchpad reads are combinational for
// the index presented; the core obeys stall; commands are single writes.
module txn_ckpt_ctrl #(
    parameter int             NREGS      = 32,
    parameter int             XLEN       = 32,
    parameter int             AW         = 16,
    parameter logic [AW-1:0]  CTRL_ADDR  = 16'hFF00,
    parameter int             BACKOFF_W  = 16,
    parameter int             LFSR_W     = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter int             BASE_SPAN  = 99
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_we,
    input  logic [AW-1:0]              ctl_addr,
    input  logic [XLEN-1:0]            ctl_wdata,
    output logic [$clog2(NREGS)-1:0]   rf_raddr,
    input  logic [XLEN-1:0]            rf_rdata,
    output logic                       rf_we,
    output logic [$clog2(NREGS)-1:0]   rf_waddr,
    output logic [XLEN-1:0]            rf_wdata,
    output logic                       sp_we,
    output logic [$clog2(NREGS)-1:0]   sp_addr,
    output logic [XLEN-1:0]            sp_wdata,
    input  logic [XLEN-1:0]            sp_rdata,
    input  logic                       abort_in,
    output logic                       stall,
    output logic                       low_power,
    output logic                       restart,
    output logic                       txn_active
);
    import txn_pkg::*;

    localparam int IDX_W = $clog2(NREGS);

    txn_state_e       state_q, state_d;
    logic             pend_q;
    logic             cmd_hit, start_cmd, stop_cmd;
    logic [IDX_W-1:0] idx;
    logic             idx_last;
    logic             copy_adv;
    logic [LFSR_W-1:0] rnd;
    logic             bo_arm, bo_commit, bo_count, bo_expired;

    // Decode the memory-mapped command word.
    always_comb begin
        cmd_hit   = ctl_we && (ctl_addr == CTRL_ADDR);
        start_cmd = cmd_hit && (ctl_wdata == XLEN'(1));
        stop_cmd  = cmd_hit && (ctl_wdata == '0);
    end

    // Next-state logic of the transaction sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_cmd) state_d = ST_SAVE;
            ST_SAVE:    if (idx_last) state_d = (pend_q || abort_in) ? ST_RESTORE : ST_RUN;
            ST_RUN:     if (abort_in) state_d = ST_RESTORE;
                        else if (stop_cmd) state_d = ST_IDLE;
            ST_RESTORE: if (idx_last) state_d = ST_BACKOFF;
            ST_BACKOFF: if (bo_expired) state_d = ST_WAKE;
            ST_WAKE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and pending-abort latch for conflicts during save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SAVE)  pend_q <= 1'b0;
            else if (abort_in)       pend_q <= 1'b1;
        end
    end

    // Control strobes for the sub-blocks.
    always_comb begin
        copy_adv  = (state_q == ST_SAVE) || (state_q == ST_RESTORE);
        bo_arm    = (state_q == ST_RESTORE) && idx_last;
        bo_commit = (state_q == ST_RUN) && stop_cmd && !abort_in;
        bo_count  = (state_q == ST_BACKOFF) && !bo_expired;
    end

    txn_copy_seq #(.N(NREGS), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (copy_adv),
        .idx     (idx),
        .last    (idx_last)
    );

    txn_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    txn_backoff #(.BW(BACKOFF_W), .LW(LFSR_W), .SPAN(BASE_SPAN)) u_bo (
        .clk      (clk),
        .rst_n    (rst_n),
        .rand_in  (rnd),
        .arm      (bo_arm),
        .commit   (bo_commit),
        .count_en (bo_count),
        .expired  (bo_expired)
    );

    // Port drive for copy paths and core-facing status.
    always_comb begin
        rf_raddr   = idx;
        sp_addr    = idx;
        rf_waddr   = idx;
        sp_we      = (state_q == ST_SAVE);
        sp_wdata   = rf_rdata;
        rf_we      = (state_q == ST_RESTORE);
        rf_wdata   = sp_rdata;
        low_power  = (state_q == ST_BACKOFF);
        restart    = (state_q == ST_WAKE);
        txn_active = (state_q == ST_RUN);
        stall      = (state_q == ST_SAVE) || (state_q == ST_RESTORE) ||
                     (state_q == ST_BACKOFF) || (state_q == ST_WAKE);
    end
endmodule

// File: rtl/txn_ckpt_ctrl_chk.sv
// Protocol checker for txn_ckpt_ctrl, attached by bind.
// Assumes: only port-level signals of the controller are observed.
module txn_ckpt_ctrl_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sp_we,
    input logic [IDX_W-1:0] sp_addr,
    input logic             rf_we,
    input logic [IDX_W-1:0] rf_waddr,
    input logic             stall,
    input logic             low_power,
    input logic             restart,
    input logic             txn_active
);
    p_save_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (stall && !txn_active));
    p_save_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sp_we) |-> (sp_addr == '0));
    p_save_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && $past(sp_we)) |-> (sp_addr == $past(sp_addr) + 1'b1));
    p_active_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_active |-> !stall);
    p_restore_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_we) |-> (rf_waddr == '0));
    p_restore_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_waddr == $past(rf_waddr) + 1'b1));
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && sp_we));
    p_restore_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> stall);
    p_lp_after_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> $past(rf_we));
    p_lp_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> (stall && !rf_we && !sp_we));
    p_restart_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(low_power) && !low_power));
    p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!restart && !stall));
endmodule

bind txn_ckpt_ctrl txn_ckpt_ctrl_chk #(.IDX_W($clog2(NREGS))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sp_we      (sp_we),
    .sp_addr    (sp_addr),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .stall      (stall),
    .low_power  (low_power),
    .restart    (restart),
    .txn_active (txn_active)
);

// File: tb/txn_ckpt_ctrl_test.sv
module txn_ckpt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR   = 32;
    localparam int XL   = 32;
    localparam int AW   = 16;
    localparam int BW   = 10;
    localparam int MAXD = (1 << BW) - 1;
    localparam logic [AW-1:0] CTRL = 16'hFF00;
    localparam int IW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0;
    logic [AW-1:0] ctl_addr = '0;
    logic [XL-1:0] ctl_wdata = '0;
    logic abort_in = 1'b0;
    logic [IW-1:0] rf_raddr, rf_waddr, sp_addr;
    logic [XL-1:0] rf_rdata, rf_wdata, sp_wdata, sp_rdata;
    logic rf_we, sp_we, stall, low_power, restart, txn_active;

    logic [XL-1:0] rf   [NR];
    logic [XL-1:0] sp   [NR];
    logic [XL-1:0] snap [NR];

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_ckpt_ctrl #(.NREGS(NR), .XLEN(XL), .AW(AW), .CTRL_ADDR(CTRL),
                    .BACKOFF_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
        .sp_rdata(sp_rdata), .abort_in(abort_in), .stall(stall),
        .low_power(low_power), .restart(restart), .txn_active(txn_active));

    assign rf_rdata = rf[rf_raddr];
    assign sp_rdata = sp[sp_addr];

    always @(posedge clk) begin
        if (sp_we) sp[sp_addr] <= sp_wdata;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Issue one command write at a negedge; returns at the next negedge.
    task automatic cmd(input logic [AW-1:0] a, input logic [XL-1:0] d);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Start a transaction and check the checkpoint; optional abort at word abort_at.
    task automatic start_txn(input int abort_at);
        bit bad = 1'b0;
        int bad_k = -1;
        for (int k = 0; k < NR; k++) snap[k] = rf[k];
        ctl_we = 1'b1; ctl_addr = CTRL; ctl_wdata = 1;
        for (int k = 0; k < NR; k++) begin
            @(negedge clk);
            ctl_we = 1'b0;
            abort_in = (k == abort_at);
            if (!(sp_we && stall && sp_addr == IW'(k) && rf_raddr == IW'(k))) begin
                bad = 1'b1; if (bad_k < 0) bad_k = k;
            end
        end
        abort_in = 1'b0;
        check(!bad, "R2 save word order/stall", bad_k, -1);
        @(negedge clk);
        bad = 1'b0;
        for (int k = 0; k < NR; k++) if (sp[k] != snap[k]) bad = 1'b1;
        check(!bad, "R2 saved words match registers", bad, 0);
        if (abort_at < 0)
            check(txn_active && !stall, "R2 active after save", int'(txn_active), 1);
        else
            check(rf_we && rf_waddr == '0 && !txn_active, "R6 restore follows full save",
                  int'(rf_we), 1);
    endtask

    // Corrupt the live registers as speculative execution would.
    task automatic corrupt();
        for (int k = 0; k < NR; k++) rf[k] = rf[k] ^ (32'h5A5A_0001 + 32'(k) * 32'h0001_0203);
    endtask

    // At the first restore cycle: check restore, measure backoff, check wake.
    task automatic restore_and_wait(input bit poke, output int len);
        bit bad = 1'b0;
        int bad_k = -1;
        int n = 0;
        bit lp_ok = 1'b1;
        for (int k = 0; k < NR; k++) begin
            if (!(rf_we && stall && rf_waddr == IW'(k))) begin
                bad = 1'b1; if (bad_k < 0) bad_k = k;
            end
            abort_in = poke && (k == 4);
            @(negedge clk);
        end
        abort_in = 1'b0;
        check(!bad, "R5 restore word order/stall", bad_k, -1);
        bad = 1'b0;
        for (int k = 0; k < NR; k++) if (rf[k] != snap[k]) bad = 1'b1;
        check(!bad, "R5 registers restored from checkpoint", bad, 0);
        check(low_power && !rf_we, "R7 low power right after restore", int'(low_power), 1);
        while (low_power && n < 4000) begin
            if (!stall) lp_ok = 1'b0;
            n++;
            abort_in = poke && (n == 2);
            @(negedge clk);
        end
        abort_in = 1'b0;
        check(lp_ok, "R7 stall held in low power", int'(lp_ok), 1);
        check(restart && stall, "R7 restart after wait", int'(restart), 1);
        @(negedge clk);
        check(!restart && !stall && !low_power, "R7 idle after restart", int'(stall), 0);
        len = n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        int prev;
        int len;
        int exp;
        for (int k = 0; k < NR; k++) begin
            rf[k] = 32'hC000_0000 + 32'(k) * 32'h0101_0107;
            sp[k] = '0;
        end
        // R1 reset
        repeat (3) @(negedge clk);
        check(!stall && !low_power && !restart && !txn_active && !sp_we && !rf_we,
              "R1 outputs in reset", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!stall && !low_power && !restart && !txn_active && !sp_we && !rf_we,
              "R1 outputs after reset", int'(stall), 0);

        // R3 ignored writes while idle
        cmd(16'h1234, 1);
        check(!stall && !sp_we, "R3 other address ignored", int'(stall), 0);
        cmd(CTRL, 2);
        check(!stall && !sp_we, "R3 unknown value ignored", int'(stall), 0);
        cmd(CTRL, 0);
        check(!stall && !txn_active, "R3 stop while idle ignored", int'(stall), 0);

        // R11 abort while idle
        abort_in = 1'b1; @(negedge clk); abort_in = 1'b0;
        check(!stall && !rf_we && !low_power, "R11 abort while idle ignored", int'(rf_we), 0);
        repeat (2) @(negedge clk);
        check(!stall && !low_power, "R11 still idle", int'(stall), 0);

        // R2, R3 and R4: start, ignored commands while active, commit
        start_txn(-1);
        cmd(CTRL, 1);
        check(txn_active && !sp_we, "R3 start while active ignored", int'(sp_we), 0);
        cmd(16'h0000, 0);
        check(txn_active, "R3 stop to other address ignored", int'(txn_active), 1);
        corrupt();
        snap[0] = rf[0];
        cmd(CTRL, 0);
        check(!txn_active && !stall && !rf_we, "R4 commit ends transaction", int'(txn_active), 0);
        repeat (3) @(negedge clk);
        check(rf[0] == snap[0] && !rf_we, "R4 no restore after commit", int'(rf_we), 0);

        // R5..R9, R11: repeated conflicts with doubling
        prev = 0;
        for (int a = 0; a < 12; a++) begin
            if (a == 2) begin
                start_txn(7);                      // R6 abort during save
            end else begin
                start_txn(-1);
                corrupt();
                if (a == 3) begin                  // R5 conflict beats commit
                    ctl_we = 1'b1; ctl_addr = CTRL; ctl_wdata = 0;
                end
                abort_in = 1'b1;
                @(negedge clk);
                abort_in = 1'b0; ctl_we = 1'b0;
            end
            restore_and_wait(a == 5, len);
            if (a == 0) begin
                check(len >= 1 && len <= 99, "R8 first backoff below 100", len, 99);
            end else begin
                exp = (2 * prev > MAXD) ? MAXD : 2 * prev;
                check(len == exp, (a == 6) ? "R11 abort in wait ignored, R9 doubling"
                                           : "R9 backoff doubles", len, exp);
            end
            prev = len;
        end
        check(prev == MAXD, "R9 backoff saturates", prev, MAXD);

        // R10: commit clears history
        start_txn(-1);
        cmd(CTRL, 0);
        check(!txn_active && !stall, "R4 commit after retries", int'(txn_active), 0);
        start_txn(-1);
        corrupt();
        abort_in = 1'b1; @(negedge clk); abort_in = 1'b0;
        restore_and_wait(1'b0, len);
        check(len >= 1 && len <= 99, "R10 fresh backoff after commit", len, 99);

        summary();
    end
endmodule